// File: doc/BRIEF.md
# Next-Interrupt Claim CSR Unit

This block serves the machine-mode CSR that a software interrupt trampoline reads to pick up the next pending interrupt. It takes the best pending interrupt offered by the interrupt controller, together with its privilege, level, id, vectoring style and trigger type. From that interrupt and the saved previous level, the level threshold and the handler table base, it decides whether a handler could take the interrupt. One CSR access does two things. It applies its operand to the status enable bits, and it can also claim the interrupt.

An interrupt is claimed only when the access writes and the interrupt is suitable. A claim moves the interrupt id into the exception code and the interrupt level into the current level. An edge-triggered interrupt also gets a one-cycle pending-clear strobe. If the access does not write, no state changes, but the read value still shows whether an interrupt is available. The read value is the address of the handler table entry, or zero if no interrupt is suitable. All results appear one cycle after the access.

Top module: `nxti_claim_unit`

## Requirements
- R1: A set access (op 3'b010 register form, op 3'b110 immediate form) ORs its operand into the status bits, and a clear-immediate access (op 3'b111) clears the bits set in its 5-bit immediate. This happens whether or not an interrupt is suitable, and the new status appears one cycle after the access.
- R2: An interrupt is suitable only when all four of these hold: its privilege is machine (2'b11), its level is strictly above the saved previous level, its level is strictly above the threshold, and its hardware-vectored flag is 0.
- R3: One cycle after every access, rsp_valid is 1. rsp_rdata is the table base plus id times XLEN/8 when the interrupt is suitable, and 0 otherwise.
- R4: A writing access with a suitable interrupt sets exc_code to the interrupt id and cur_level to the interrupt level.
- R5: A claim of an edge-triggered interrupt (top_edge=1) pulses pend_clr for one cycle with pend_clr_id equal to the id. A claim of a level-triggered interrupt gives no pulse.
- R6: An access that does not write changes neither the status bits, nor cur_level, nor exc_code, and gives no pend_clr pulse. Such an access is a register-form set with csr_src_x0=1, or an immediate form with a zero immediate (csr_src[4:0]).
- R7: Any other op code sets rsp_illegal, returns read data 0 and changes no state.
- R8: A claim sets cur_level to the claimed level even when that level is below the current level.
- R9: After reset, the status bits, cur_level, exc_code and all response outputs are 0.
- R10: A cycle with csr_valid=0 changes no state and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_valid | input | 1 | CSR access in this cycle |
| csr_op | input | 3 | Access kind: 010 set, 110 set-immediate, 111 clear-immediate, others illegal |
| csr_src | input | XLEN | Register operand, or the zero-extended immediate in bits 4:0 |
| csr_src_x0 | input | 1 | Register operand names the zero register |
| top_priv | input | 2 | Privilege of the best pending interrupt |
| top_level | input | LVL_W | Level of the best pending interrupt |
| top_id | input | ID_W | Id of the best pending interrupt |
| top_hw_vec | input | 1 | Best pending interrupt is hardware vectored |
| top_edge | input | 1 | Best pending interrupt is edge triggered |
| prev_level | input | LVL_W | Saved previous interrupt level |
| thresh | input | LVL_W | Machine-mode level threshold |
| tbl_base | input | XLEN | Handler table base address |
| rsp_valid | output | 1 | Response for the previous access |
| rsp_rdata | output | XLEN | Read value |
| rsp_illegal | output | 1 | Previous access used a forbidden op |
| status_bits | output | XLEN | Status enable bits |
| cur_level | output | LVL_W | Current interrupt level |
| exc_code | output | ID_W | Exception code |
| pend_clr | output | 1 | Pending-clear strobe |
| pend_clr_id | output | ID_W | Id whose pending bit is cleared |

## Verification
Random accesses use levels drawn from a small range, so the interrupt level often ties the previous level or the threshold. This separates the strict comparisons from non-strict ones. Privilege, vectoring and trigger type are randomized on their own, so each factor of suitability and the strobe are tried separately. Directed cases cover zero-immediate and zero-register reads, which must not write. They also cover illegal ops, a claim that lowers the level, and the difference between set and clear on the status bits.

// File: rtl/nxti_pkg.sv
package nxti_pkg;
    typedef enum logic [2:0] {
        OP_RW  = 3'b001,
        OP_RS  = 3'b010,
        OP_RC  = 3'b011,
        OP_RWI = 3'b101,
        OP_RSI = 3'b110,
        OP_RCI = 3'b111
    } csr_op_e;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;
    localparam int unsigned IMM_W = 5;
endpackage

// File: rtl/nxti_decode.sv
module nxti_decode #(
    parameter int unsigned XLEN = 32
) (
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] src,
    input  logic            src_x0,
    output logic            legal,
    output logic            writes,
    output logic [XLEN-1:0] set_mask,
    output logic [XLEN-1:0] clr_mask
);
    import nxti_pkg::*;

    logic [XLEN-1:0] imm_ext;

    always_comb begin
        imm_ext = '0;
        imm_ext[IMM_W-1:0] = src[IMM_W-1:0];
        legal    = 1'b0;
        writes   = 1'b0;
        set_mask = '0;
        clr_mask = '0;
        case (op)
            OP_RS: begin
                legal    = 1'b1;
                writes   = !src_x0;
                set_mask = src_x0 ? '0 : src;
            end
            OP_RSI: begin
                legal    = 1'b1;
                writes   = (imm_ext != '0);
                set_mask = imm_ext;
            end
            OP_RCI: begin
                legal    = 1'b1;
                writes   = (imm_ext != '0);
                clr_mask = imm_ext;
            end
            default: begin
                legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/nxti_suit.sv
module nxti_suit #(
    parameter int unsigned LVL_W = 8
) (
    input  logic [1:0]       priv,
    input  logic [LVL_W-1:0] level,
    input  logic             hw_vec,
    input  logic [LVL_W-1:0] prev_level,
    input  logic [LVL_W-1:0] thresh,
    output logic             suitable
);
    import nxti_pkg::*;

    logic is_machine;
    logic above_prev;
    logic above_thresh;

    always_comb begin
        is_machine   = (priv == PRIV_MACHINE);
        above_prev   = (level > prev_level);
        above_thresh = (level > thresh);
        suitable     = is_machine && above_prev && above_thresh && !hw_vec;
    end
endmodule

// File: rtl/nxti_vec_addr.sv
module nxti_vec_addr #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned ID_W = 12
) (
    input  logic [XLEN-1:0] base,
    input  logic [ID_W-1:0] id,
    input  logic            suitable,
    output logic [XLEN-1:0] addr
);
    localparam int unsigned ENTRY_BYTES = XLEN / 8;
    localparam int unsigned ENTRY_SHIFT = $clog2(ENTRY_BYTES);

    logic [XLEN-1:0] offset;

    generate
        if (XLEN > ID_W + ENTRY_SHIFT) begin : g_wide
            always_comb begin
                offset = '0;
                offset[ID_W+ENTRY_SHIFT-1:0] = {id, {ENTRY_SHIFT{1'b0}}};
            end
        end else begin : g_narrow
            logic [ID_W+ENTRY_SHIFT-1:0] full_off;
            always_comb begin
                full_off = {id, {ENTRY_SHIFT{1'b0}}};
                offset   = full_off[XLEN-1:0];
            end
        end
    endgenerate

    always_comb begin
        addr = suitable ? (base + offset) : '0;
    end
endmodule

// File: rtl/nxti_claim_unit.sv
module nxti_claim_unit #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned LVL_W = 8,
    parameter int unsigned ID_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_valid,
    input  logic [2:0]       csr_op,
    input  logic [XLEN-1:0]  csr_src,
    input  logic             csr_src_x0,
    input  logic [1:0]       top_priv,
    input  logic [LVL_W-1:0] top_level,
    input  logic [ID_W-1:0]  top_id,
    input  logic             top_hw_vec,
    input  logic             top_edge,
    input  logic [LVL_W-1:0] prev_level,
    input  logic [LVL_W-1:0] thresh,
    input  logic [XLEN-1:0]  tbl_base,
    output logic             rsp_valid,
    output logic [XLEN-1:0]  rsp_rdata,
    output logic             rsp_illegal,
    output logic [XLEN-1:0]  status_bits,
    output logic [LVL_W-1:0] cur_level,
    output logic [ID_W-1:0]  exc_code,
    output logic             pend_clr,
    output logic [ID_W-1:0]  pend_clr_id
);
    typedef struct packed {
        logic             rsp_valid;
        logic [XLEN-1:0]  rdata;
        logic             illegal;
        logic [XLEN-1:0]  status;
        logic [LVL_W-1:0] level;
        logic [ID_W-1:0]  code;
        logic             clr;
        logic [ID_W-1:0]  clr_id;
    } claim_state_t;

    claim_state_t st_d, st_q;

    logic            dec_legal;
    logic            dec_writes;
    logic [XLEN-1:0] dec_set;
    logic [XLEN-1:0] dec_clr;
    logic            int_ok;
    logic [XLEN-1:0] vec_addr;

    nxti_decode #(.XLEN(XLEN)) u_decode (
        .op       (csr_op),
        .src      (csr_src),
        .src_x0   (csr_src_x0),
        .legal    (dec_legal),
        .writes   (dec_writes),
        .set_mask (dec_set),
        .clr_mask (dec_clr)
    );

    nxti_suit #(.LVL_W(LVL_W)) u_suit (
        .priv       (top_priv),
        .level      (top_level),
        .hw_vec     (top_hw_vec),
        .prev_level (prev_level),
        .thresh     (thresh),
        .suitable   (int_ok)
    );

    nxti_vec_addr #(.XLEN(XLEN), .ID_W(ID_W)) u_vec (
        .base     (tbl_base),
        .id       (top_id),
        .suitable (int_ok),
        .addr     (vec_addr)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rdata     = '0;
        st_d.illegal   = 1'b0;
        st_d.clr       = 1'b0;
        st_d.clr_id    = '0;
        if (csr_valid) begin
            st_d.rsp_valid = 1'b1;
            if (!dec_legal) begin
                st_d.illegal = 1'b1;
            end else begin
                st_d.rdata = vec_addr;
                if (dec_writes) begin
                    st_d.status = (st_q.status | dec_set) & ~dec_clr;
                    if (int_ok) begin
                        st_d.code  = top_id;
                        st_d.level = top_level;
                        if (top_edge) begin
                            st_d.clr    = 1'b1;
                            st_d.clr_id = top_id;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid   = st_q.rsp_valid;
    assign rsp_rdata   = st_q.rdata;
    assign rsp_illegal = st_q.illegal;
    assign status_bits = st_q.status;
    assign cur_level   = st_q.level;
    assign exc_code    = st_q.code;
    assign pend_clr    = st_q.clr;
    assign pend_clr_id = st_q.clr_id;
endmodule

// File: rtl/nxti_claim_checker.sv
module nxti_claim_checker #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned LVL_W = 8,
    parameter int unsigned ID_W  = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csr_valid,
    input logic [2:0]       csr_op,
    input logic             rsp_valid,
    input logic [XLEN-1:0]  rsp_rdata,
    input logic             rsp_illegal,
    input logic [XLEN-1:0]  status_bits,
    input logic [LVL_W-1:0] cur_level,
    input logic [ID_W-1:0]  exc_code,
    input logic             pend_clr,
    input logic [ID_W-1:0]  pend_clr_id
);
    // R1: a set access never removes a status bit
    a_r1_set_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && (csr_op == 3'b010 || csr_op == 3'b110))
        |=> ((status_bits & $past(status_bits)) == $past(status_bits)));

    // R5: strobe carries the code just claimed
    a_r5_clr_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr |-> (exc_code == pend_clr_id && rsp_valid));

    // R7: illegal access leaves state alone and reads zero
    a_r7_illegal_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && !(csr_op == 3'b010 || csr_op == 3'b110 || csr_op == 3'b111))
        |=> (rsp_illegal && rsp_rdata == '0 && !pend_clr
             && $stable(status_bits) && $stable(cur_level) && $stable(exc_code)));

    // R10: idle cycle changes nothing
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_valid |=> (!rsp_valid && !pend_clr && $stable(status_bits)
                        && $stable(cur_level) && $stable(exc_code)));

    // R3: response follows each access
    a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        csr_valid |=> rsp_valid);

    // R7: flag and strobe never together
    a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_illegal, pend_clr}));
endmodule

bind nxti_claim_unit nxti_claim_checker #(.XLEN(XLEN), .LVL_W(LVL_W), .ID_W(ID_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_valid   (csr_valid),
    .csr_op      (csr_op),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_illegal (rsp_illegal),
    .status_bits (status_bits),
    .cur_level   (cur_level),
    .exc_code    (exc_code),
    .pend_clr    (pend_clr),
    .pend_clr_id (pend_clr_id)
);

// File: tb/nxti_claim_unit_tb_top.sv
module nxti_claim_unit_tb_top;
    localparam int unsigned XLEN  = 32;
    localparam int unsigned LVL_W = 8;
    localparam int unsigned ID_W  = 12;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned N_RANDOM = 3000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             csr_valid = 1'b0;
    logic [2:0]       csr_op = '0;
    logic [XLEN-1:0]  csr_src = '0;
    logic             csr_src_x0 = 1'b0;
    logic [1:0]       top_priv = '0;
    logic [LVL_W-1:0] top_level = '0;
    logic [ID_W-1:0]  top_id = '0;
    logic             top_hw_vec = 1'b0;
    logic             top_edge = 1'b0;
    logic [LVL_W-1:0] prev_level = '0;
    logic [LVL_W-1:0] thresh = '0;
    logic [XLEN-1:0]  tbl_base = '0;
    logic             rsp_valid;
    logic [XLEN-1:0]  rsp_rdata;
    logic             rsp_illegal;
    logic [XLEN-1:0]  status_bits;
    logic [LVL_W-1:0] cur_level;
    logic [ID_W-1:0]  exc_code;
    logic             pend_clr;
    logic [ID_W-1:0]  pend_clr_id;

    int unsigned n_checks = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    // bench model state
    logic [XLEN-1:0]  m_status = '0;
    logic [LVL_W-1:0] m_level = '0;
    logic [ID_W-1:0]  m_code = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nxti_claim_unit #(.XLEN(XLEN), .LVL_W(LVL_W), .ID_W(ID_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_op(csr_op),
        .csr_src(csr_src), .csr_src_x0(csr_src_x0), .top_priv(top_priv),
        .top_level(top_level), .top_id(top_id), .top_hw_vec(top_hw_vec),
        .top_edge(top_edge), .prev_level(prev_level), .thresh(thresh),
        .tbl_base(tbl_base), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_illegal(rsp_illegal), .status_bits(status_bits),
        .cur_level(cur_level), .exc_code(exc_code), .pend_clr(pend_clr),
        .pend_clr_id(pend_clr_id)
    );

    function automatic bit f_suitable();
        return (top_priv == 2'b11) && (top_level > prev_level)
               && (top_level > thresh) && !top_hw_vec;
    endfunction

    function automatic bit f_legal();
        return csr_op == 3'b010 || csr_op == 3'b110 || csr_op == 3'b111;
    endfunction

    function automatic bit f_writes();
        if (csr_op == 3'b010) return !csr_src_x0;
        return csr_src[4:0] != 5'd0;
    endfunction

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply current inputs for one cycle and check all outputs against the model.
    task automatic step(input string tag);
        logic             e_valid, e_ill, e_clr;
        logic [XLEN-1:0]  e_rdata;
        logic [ID_W-1:0]  e_clr_id;
        logic [XLEN-1:0]  imm;
        e_valid = csr_valid; e_ill = 1'b0; e_clr = 1'b0;
        e_rdata = '0; e_clr_id = '0;
        imm = {{(XLEN-5){1'b0}}, csr_src[4:0]};
        if (csr_valid) begin
            if (!f_legal()) begin
                e_ill = 1'b1;
            end else begin
                if (f_suitable()) e_rdata = tbl_base + XLEN'(top_id) * (XLEN/8);
                if (f_writes()) begin
                    if (csr_op == 3'b010) m_status = m_status | csr_src;
                    else if (csr_op == 3'b110) m_status = m_status | imm;
                    else m_status = m_status & ~imm;
                    if (f_suitable()) begin
                        m_code = top_id;
                        m_level = top_level;
                        if (top_edge) begin
                            e_clr = 1'b1;
                            e_clr_id = top_id;
                        end
                    end
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R3 valid"}, XLEN'(rsp_valid), XLEN'(e_valid));
        chk({tag, " R3 rdata"}, rsp_rdata, e_rdata);
        chk({tag, " R7 illegal"}, XLEN'(rsp_illegal), XLEN'(e_ill));
        chk({tag, " R1 status"}, status_bits, m_status);
        chk({tag, " R4 level"}, XLEN'(cur_level), XLEN'(m_level));
        chk({tag, " R4 code"}, XLEN'(exc_code), XLEN'(m_code));
        chk({tag, " R5 clr"}, XLEN'(pend_clr), XLEN'(e_clr));
        chk({tag, " R5 clr_id"}, XLEN'(pend_clr_id), XLEN'(e_clr_id));
    endtask

    task automatic set_int(input logic [1:0] p, input int lvl, input int id,
                           input bit hw, input bit edg, input int pl, input int th);
        top_priv = p; top_level = LVL_W'(lvl); top_id = ID_W'(id);
        top_hw_vec = hw; top_edge = edg; prev_level = LVL_W'(pl); thresh = LVL_W'(th);
    endtask

    task automatic access(input logic [2:0] op, input logic [XLEN-1:0] src, input bit x0, input string tag);
        csr_valid = 1'b1; csr_op = op; csr_src = src; csr_src_x0 = x0;
        step(tag);
        csr_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        tbl_base = 32'h0000_8000;
        repeat (3) @(negedge clk);
        // R9: reset values
        chk("R9 status", status_bits, '0);
        chk("R9 level", XLEN'(cur_level), '0);
        chk("R9 code", XLEN'(exc_code), '0);
        chk("R9 valid", XLEN'(rsp_valid), '0);
        chk("R9 clr", XLEN'(pend_clr), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: pure reads with a suitable interrupt present
        set_int(2'b11, 5, 7, 0, 1, 0, 0);
        access(3'b010, '0, 1'b1, "R6 rs x0");
        access(3'b110, 32'h20, 1'b0, "R6 rsi zero imm");
        access(3'b111, 32'h0, 1'b0, "R6 rci zero imm");
        // R10: idle
        step("R10 idle");
        // R4/R5: edge claim
        access(3'b110, 32'h8, 1'b0, "R4 R5 edge claim");
        // R5: level-triggered claim, no strobe
        set_int(2'b11, 9, 3, 0, 0, 2, 1);
        access(3'b010, 32'h3, 1'b0, "R5 level trig claim");
        // R8: lower level claim
        set_int(2'b11, 4, 11, 0, 1, 1, 2);
        access(3'b110, 32'h1, 1'b0, "R8 level drop");
        // R2: ties and filters
        set_int(2'b11, 3, 5, 0, 1, 3, 0);
        access(3'b110, 32'h1, 1'b0, "R2 tie prev");
        set_int(2'b11, 3, 5, 0, 1, 0, 3);
        access(3'b110, 32'h1, 1'b0, "R2 tie thresh");
        set_int(2'b11, 6, 5, 1, 1, 0, 0);
        access(3'b110, 32'h1, 1'b0, "R2 hw vectored");
        set_int(2'b01, 6, 5, 0, 1, 0, 0);
        access(3'b110, 32'h1, 1'b0, "R2 supervisor");
        // R1: clear immediate
        access(3'b111, 32'h9, 1'b0, "R1 rci clears");
        // R7: illegal ops
        set_int(2'b11, 8, 2, 0, 1, 0, 0);
        access(3'b001, 32'hff, 1'b0, "R7 rw");
        access(3'b011, 32'hff, 1'b0, "R7 rc");
        access(3'b101, 32'h1f, 1'b0, "R7 rwi");
        access(3'b000, 32'h1f, 1'b0, "R7 zero op");

        for (int i = 0; i < N_RANDOM; i++) begin
            logic [2:0] ops [0:7];
            ops[0] = 3'b010; ops[1] = 3'b110; ops[2] = 3'b111; ops[3] = 3'b010;
            ops[4] = 3'b110; ops[5] = 3'b001; ops[6] = 3'b011; ops[7] = 3'b100;
            set_int(($urandom % 4 == 0) ? 2'($urandom) : 2'b11, int'($urandom % 5),
                    int'($urandom % 4096), ($urandom % 4) == 0, $urandom % 2,
                    int'($urandom % 4), int'($urandom % 4));
            tbl_base = $urandom & 32'hffff_ffc0;
            csr_valid = ($urandom % 5) != 0;
            csr_op = ops[$urandom % 8];
            csr_src = ($urandom % 3 == 0) ? '0 : (32'h1 << ($urandom % 32));
            csr_src_x0 = ($urandom % 4) == 0;
            if (csr_src_x0) csr_src = '0;
            step("R2 R4 random");
        end
        csr_valid = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule